// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block governs how a CAN node returns from the bus-off state. Once the protocol engine reports that the node has gone bus-off, the block watches the sampled bus level at each bit boundary. It counts runs of consecutive recessive bits; each complete run is one idle sequence. When enough idle sequences have been seen, the node rejoins the bus. On rejoin the block drops its bus-off status and pulses a reset for the transmit and receive error counters.

A host-controlled hold bit can keep the node in bus-off. The block samples the hold bit when bus-off begins. If the hold was set at entry, the node stays in bus-off until the host clears the bit.

- If the clear comes before the full count of sequences, recovery ends exactly as it would have without the hold.
- If the clear comes after the full count, the node must see one more complete idle sequence before it rejoins.

Once the hold has been released, or if it was clear at entry, raising it again has no effect until the next bus-off.

Top module: `can_boff_recovery`

## Requirements
- R1: After reset `bus_off`, `rejoin` and `ec_clear` are all 0.
- R2: An `enter_boff` pulse while not in bus-off sets `bus_off` from the next cycle. An `enter_boff` pulse while already in bus-off is ignored and does not restart the recovery count.
- R3: One idle sequence is `RUN_LEN` consecutive `bit_tick` cycles with `rx_bit`=1 (recessive). A tick with `rx_bit`=0 (dominant) restarts the run. Cycles without `bit_tick` leave the run unchanged.
- R4: With the hold clear at entry, the clock edge that takes the last tick of the `SEQ_TARGET`-th sequence also clears `bus_off`.
- R5: `rejoin` and `ec_clear` rise together, in the same cycle that `bus_off` falls, and each lasts exactly one cycle.
- R6: With `recov_hold`=1 at entry and held at 1, `bus_off` stays 1 whatever the number of sequences.
- R7: If `recov_hold` falls before `SEQ_TARGET` sequences have been counted, rejoin happens at the same tick as it would with no hold.
- R8: If `recov_hold` falls after `SEQ_TARGET` or more sequences have been counted, the sequence count stays saturated. Any partial run in progress is discarded, and rejoin happens on the last tick of one further full sequence.
- R9: Raising `recov_hold` again after it was released in the same bus-off does not delay rejoin.
- R10: If `recov_hold` was 0 at entry, raising it during that bus-off does not delay rejoin.
- R11: While not in bus-off, bit ticks never produce `rejoin` or `ec_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit's sample point |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| enter_boff | input | 1 | Pulse from the error logic: node enters bus-off |
| recov_hold | input | 1 | Host hold bit; when set at entry, blocks automatic recovery |
| bus_off | output | 1 | Node is in bus-off |
| rejoin | output | 1 | One-cycle strobe: node rejoins the bus |
| ec_clear | output | 1 | One-cycle pulse resetting the error counters |

## Verification
The bench builds the block with `RUN_LEN`=3 and `SEQ_TARGET`=4, so a full recovery takes twelve recessive ticks instead of 1408. With these values every ordering can be tried in a short run: an early release, a late release after saturation, re-raising the hold, and dominant interruptions. The exact tick that ends bus-off is checked on both sides: one tick short and on the tick itself. The saturation case sends twenty sequences' worth of idle bits, well past the target.

// File: rtl/boff_pkg.sv
package boff_pkg;

  // Next value of the recessive-run counter for one sampled bit.
  // A dominant bit restarts the run; a completed run wraps to zero.
  function automatic int unsigned run_step(int unsigned run, logic recessive,
                                           int unsigned len);
    if (!recessive) return 0;
    if (run + 1 >= len) return 0;
    return run + 1;
  endfunction

  // Saturating increment of the sequence counter.
  function automatic int unsigned sat_step(int unsigned cnt, int unsigned top);
    return (cnt >= top) ? top : cnt + 1;
  endfunction

endpackage

// File: rtl/boff_run_counter.sv
module boff_run_counter #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic rx_bit,
  output logic seq_done
);
  import boff_pkg::*;

  localparam int RW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (clr)  run_q <= '0;
    else if (tick) run_q <= RW'(run_step(32'(run_q), rx_bit, RUN_LEN));
  end

  assign seq_done = !clr && tick && rx_bit && (run_q == LAST);

  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);
  assert_dominant_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !rx_bit |=> run_q == '0);
  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr |=> $stable(run_q));

endmodule

// File: rtl/boff_seq_counter.sv
module boff_seq_counter #(
  parameter int SEQ_TARGET = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full,
  output logic reach
);
  import boff_pkg::*;

  localparam int SW = $clog2(SEQ_TARGET + 1);
  localparam logic [SW-1:0] TOP = SW'(SEQ_TARGET);

  logic [SW-1:0] cnt_q;
  logic [SW-1:0] cnt_next;

  assign cnt_next = SW'(sat_step(32'(cnt_q), SEQ_TARGET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_next;
  end

  assign full  = (cnt_q == TOP);
  assign reach = inc && (cnt_next == TOP);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  assert_full_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr |=> full);

endmodule

// File: rtl/can_boff_recovery.sv
module can_boff_recovery #(
  parameter int RUN_LEN    = 11,
  parameter int SEQ_TARGET = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_bit,
  input  logic enter_boff,
  input  logic recov_hold,
  output logic bus_off,
  output logic rejoin,
  output logic ec_clear
);

  logic boff_q, lock_q, rejoin_q, clr_q;

  // Named internal events
  logic start_ev;    // accepted bus-off entry
  logic release_ev;  // host drops the latched hold
  logic late_ev;     // release after the count has saturated
  logic seq_done;    // one full recessive run completed
  logic seq_full;    // sequence counter saturated
  logic seq_reach;   // this sequence brings the count to target
  logic rejoin_ev;   // leave bus-off now

  assign start_ev   = enter_boff && !boff_q;
  assign release_ev = boff_q && lock_q && !recov_hold;
  assign late_ev    = release_ev && seq_full;
  assign rejoin_ev  = boff_q && !lock_q && seq_reach;

  boff_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!boff_q || late_ev),
    .tick     (bit_tick),
    .rx_bit   (rx_bit),
    .seq_done (seq_done)
  );

  boff_seq_counter #(.SEQ_TARGET(SEQ_TARGET)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!boff_q),
    .inc   (seq_done),
    .full  (seq_full),
    .reach (seq_reach)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boff_q   <= 1'b0;
      lock_q   <= 1'b0;
      rejoin_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      rejoin_q <= rejoin_ev;
      clr_q    <= rejoin_ev;
      if (start_ev) begin
        boff_q <= 1'b1;
        lock_q <= recov_hold;
      end else if (rejoin_ev) begin
        boff_q <= 1'b0;
        lock_q <= 1'b0;
      end else if (release_ev) begin
        lock_q <= 1'b0;
      end
    end
  end

  assign bus_off  = boff_q;
  assign rejoin   = rejoin_q;
  assign ec_clear = clr_q;

  assert_enter_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_boff && !bus_off |=> bus_off);
  assert_rejoin_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rejoin |-> !bus_off && $past(bus_off));
  assert_rejoin_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rejoin |=> !rejoin);
  assert_clear_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ec_clear |=> !ec_clear);
  assert_hold_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off && lock_q && recov_hold |=> bus_off);
  assert_no_relock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off && !lock_q |=> !lock_q);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_off |=> !rejoin && !ec_clear);

endmodule

// File: tb/sim_can_boff_recovery.sv
module sim_can_boff_recovery;
  localparam int RL   = 3;
  localparam int TG   = 4;
  localparam int FULL = RL * TG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, rx_bit = 1'b1, enter_boff = 1'b0, recov_hold = 1'b0;
  logic bus_off, rejoin, ec_clear;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_boff_recovery #(.RUN_LEN(RL), .SEQ_TARGET(TG)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .enter_boff(enter_boff), .recov_hold(recov_hold),
    .bus_off(bus_off), .rejoin(rejoin), .ec_clear(ec_clear));

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic send(int n, logic v);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1; rx_bit = v;
      @(negedge clk);
    end
    bit_tick = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic enter(logic hold);
    recov_hold = hold; enter_boff = 1'b1;
    @(negedge clk);
    enter_boff = 1'b0;
  endtask

  task automatic expect_rejoin(string req);
    check(req, bus_off, 1'b0);
    check(req, rejoin, 1'b1);
    check(req, ec_clear, 1'b1);
    @(negedge clk);
    check(req, rejoin, 1'b0);
    check(req, ec_clear, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", bus_off, 1'b0);
    check("R1", rejoin, 1'b0);
    check("R1", ec_clear, 1'b0);
  endtask

  task automatic t_plain();
    enter(1'b0);
    check("R2", bus_off, 1'b1);
    send(FULL - 1, 1'b1);
    check("R4", bus_off, 1'b1);
    check("R5", rejoin, 1'b0);
    send(1, 1'b1);
    expect_rejoin("R4");
  endtask

  task automatic t_dominant();
    enter(1'b0);
    send(2, 1'b1); send(1, 1'b0);
    repeat (3) @(negedge clk);
    send(FULL - 1, 1'b1);
    check("R3", bus_off, 1'b1);
    send(1, 1'b1);
    expect_rejoin("R3");
  endtask

  task automatic t_reenter();
    enter(1'b0);
    send(FULL / 2, 1'b1);
    enter(1'b0);
    check("R2", bus_off, 1'b1);
    send(FULL / 2, 1'b1);
    expect_rejoin("R2");
  endtask

  task automatic t_hold();
    enter(1'b1);
    send(5 * FULL, 1'b1);
    check("R6", bus_off, 1'b1);
    recov_hold = 1'b0;
    @(negedge clk);
    send(RL, 1'b1);
    expect_rejoin("R6");
  endtask

  task automatic t_early();
    enter(1'b1);
    send(2 * RL, 1'b1);
    recov_hold = 1'b0;
    @(negedge clk);
    send(FULL - 2 * RL - 1, 1'b1);
    check("R7", bus_off, 1'b1);
    send(1, 1'b1);
    expect_rejoin("R7");
  endtask

  task automatic t_late();
    enter(1'b1);
    send(20 * RL, 1'b1);
    send(RL - 1, 1'b1);
    check("R8", bus_off, 1'b1);
    recov_hold = 1'b0;
    @(negedge clk);
    send(RL - 1, 1'b1);
    check("R8", bus_off, 1'b1);
    send(1, 1'b1);
    expect_rejoin("R8");
  endtask

  task automatic t_relock();
    enter(1'b1);
    send(RL, 1'b1);
    recov_hold = 1'b0;
    @(negedge clk);
    recov_hold = 1'b1;
    send(FULL - RL - 1, 1'b1);
    check("R9", bus_off, 1'b1);
    send(1, 1'b1);
    expect_rejoin("R9");
    recov_hold = 1'b0;
  endtask

  task automatic t_late_set();
    enter(1'b0);
    recov_hold = 1'b1;
    send(FULL - 1, 1'b1);
    check("R10", bus_off, 1'b1);
    send(1, 1'b1);
    expect_rejoin("R10");
    recov_hold = 1'b0;
  endtask

  task automatic t_idle();
    int seen = 0;
    for (int i = 0; i < 3 * FULL; i++) begin
      bit_tick = 1'b1; rx_bit = 1'b1;
      @(negedge clk);
      if (rejoin || ec_clear || bus_off) seen++;
    end
    bit_tick = 1'b0;
    check("R11", seen != 0, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_dominant();
    t_reenter();
    t_hold();
    t_early();
    t_late();
    t_relock();
    t_late_set();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule